// File: doc/BRIEF.md
# Color Filter Gain Steering Sequencer

This block chooses, pixel by pixel, which of four per-color gain codes drives the pixel gain stage in front of a sensor's analog chain. On every pixel strobe it samples the vertical and horizontal sync lines. It follows one of seven color filter array orderings, or a disabled setting, and it registers a 2-bit gain index. The 6-bit code held in the gain register that the index selects appears on the code output. A gain-enable input replaces that code with a fixed all-ones default.

Line-to-line sequencing is driven by the sampled rising edges of the horizontal sync. Each rising edge is qualified by the vertical sync edges seen since the previous horizontal rise. Two-color modes pick between two line patterns. Three-color and four-color modes cycle the index continuously. A user mode takes the index directly from the sync levels.

Top module: `cfa_gain_steer`

## Requirements
- R1: While reset is asserted, and right after it, the index is 0 and the code equals gain register 0 (or 63 when gain enable is low).
- R2: All state advances only on clock edges where the pixel strobe is high. On other edges the index holds.
- R3: The code output is gains_i bits [6k+5:6k] for index k when gain enable is 1, and it is 63 when gain enable is 0. The index itself is not affected by gain enable.
- R4: Mode value 1 has line A = 0,1,0,1… and line B = 2,3,2,3…. An HD rise preceded by a VD rise selects line A. Any other HD rise swaps to the other line. Every HD rise restarts the pattern.
- R5: Mode value 3 cycles 0,1,2. It restarts at 0 only on an HD rise preceded by a VD rise. Index 3 never appears.
- R6: Mode value 4 cycles 0,1,2,3. It restarts at 0 only on an HD rise preceded by a VD rise.
- R7: Mode value 2 works like mode 1, except that a preceding VD rise or a preceding VD fall selects line A.
- R8: Mode value 5 uses the lines of mode 1. An HD rise preceded by a VD fall selects line A. Otherwise, one preceded by a VD rise selects line B. Otherwise the current line repeats.
- R9: Mode value 6 works like mode 1, with line B = 1,2,1,2…. Index 3 never appears.
- R10: Mode value 7 sets the index to {VD,HD} as sampled on the same strobe (00→0, 01→1, 10→2, 11→3).
- R11: Mode value 0 holds the index at 0.
- R12: An HD rise is a strobe where HD is sampled 1 and was sampled 0 on the previous strobe. A VD edge counts as preceding it if it is sampled on any strobe after the previous HD rise, up to and including this one. The first pattern element appears on the index output after the clock edge that samples the HD rise, and the VD edge record then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_stb_i | input | 1 | Pixel sampling strobe |
| vd_i | input | 1 | Vertical sync level |
| hd_i | input | 1 | Horizontal sync level |
| mode_i | input | 3 | Steering mode (0 to 7) |
| gain_en_i | input | 1 | Pixel gain enable; 0 forces code 63 |
| gains_i | input | 24 | Four gain codes, gain k in bits [6k+5:6k] |
| gain_idx_o | output | 2 | Selected gain index |
| gain_code_o | output | 6 | Selected gain code |

## Verification
Each steering mode is driven through the same frame. The frame has a VD pulse followed by plain lines, lines with VD held high, and a VD fall before further lines. This separates the modes that reset on rise only, on either edge, or on the edge direction. The frame also separates modes that swap lines from mode 5, which repeats the current line. The pixel strobe is dropped in mid-line to show that the index holds. The mode is switched from four-color to three-color mid-line, which exercises the phase wrap. Mode 7 is swept over all four sync combinations. Gain enable is turned off during one frame to show that the code is overridden while the index keeps running.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  localparam int NUM_GAINS = 4;
  localparam int IDX_W     = $clog2(NUM_GAINS);
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF        = 3'd0,
    MODE_MOSAIC_SEP = 3'd1,
    MODE_INTERLACE  = 3'd2,
    MODE_TRI        = 3'd3,
    MODE_QUAD       = 3'd4,
    MODE_VD_SEL     = 3'd5,
    MODE_MOSAIC_REP = 3'd6,
    MODE_USER       = 3'd7
  } steer_mode_e;
endpackage

// File: rtl/cfa_edge_tracker.sv
module cfa_edge_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic vd_i,
  input  logic hd_i,
  output logic hd_rise_o,
  output logic vd_up_pend_o,
  output logic vd_dn_pend_o
);
  logic vd_q, hd_q, up_q, dn_q;

  assign hd_rise_o    = stb_i & hd_i & ~hd_q;
  // pending flags include an edge sampled on this same strobe
  assign vd_up_pend_o = up_q | (vd_i & ~vd_q);
  assign vd_dn_pend_o = dn_q | (~vd_i & vd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd_q <= 1'b0;
      hd_q <= 1'b0;
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (stb_i) begin
      vd_q <= vd_i;
      hd_q <= hd_i;
      if (hd_rise_o) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= vd_up_pend_o;
        dn_q <= vd_dn_pend_o;
      end
    end
  end

  p_edge_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && hd_i && !hd_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/cfa_pattern_seq.sv
module cfa_pattern_seq
  import cfa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  steer_mode_e      mode_i,
  input  logic             vd_i,
  input  logic             hd_i,
  input  logic             hd_rise_i,
  input  logic             up_pend_i,
  input  logic             dn_pend_i,
  output logic [IDX_W-1:0] idx_o
);
  logic             line_q, line_nx;
  logic [IDX_W-1:0] ph_q, ph_nx, ph_base, ph_use, idx_nx;
  logic [IDX_W:0]   len, ph_inc;
  logic             two_line, cyc_mode, restart;

  function automatic logic [IDX_W-1:0] pick(steer_mode_e m, logic ln, logic [IDX_W-1:0] ph);
    case (m)
      MODE_TRI, MODE_QUAD: pick = ph;
      MODE_MOSAIC_REP:     pick = {1'b0, ln} + {1'b0, ph[0]};
      default:             pick = {ln, ph[0]};
    endcase
  endfunction

  always_comb begin
    two_line = mode_i inside {MODE_MOSAIC_SEP, MODE_INTERLACE, MODE_VD_SEL, MODE_MOSAIC_REP};
    cyc_mode = mode_i inside {MODE_TRI, MODE_QUAD};
    restart  = hd_rise_i & (two_line | (cyc_mode & up_pend_i));
    len      = (mode_i == MODE_TRI) ? 3'd3 : (mode_i == MODE_QUAD) ? 3'd4 : 3'd2;

    line_nx = line_q;
    if (hd_rise_i) begin
      case (mode_i)
        MODE_MOSAIC_SEP, MODE_MOSAIC_REP: line_nx = up_pend_i ? 1'b0 : ~line_q;
        MODE_INTERLACE:  line_nx = (up_pend_i | dn_pend_i) ? 1'b0 : ~line_q;
        MODE_VD_SEL:     line_nx = dn_pend_i ? 1'b0 : (up_pend_i ? 1'b1 : line_q);
        default:         line_nx = line_q;
      endcase
    end

    ph_base = restart ? '0 : ph_q;
    ph_use  = ({1'b0, ph_base} >= len) ? '0 : ph_base;  // wrap after a mode change
    ph_inc  = {1'b0, ph_use} + 1'b1;
    ph_nx   = (ph_inc == len) ? '0 : ph_inc[IDX_W-1:0];

    case (mode_i)
      MODE_OFF: begin
        idx_nx = '0;
        ph_nx  = '0;
      end
      MODE_USER: begin
        idx_nx = {vd_i, hd_i};
        ph_nx  = '0;
      end
      default: idx_nx = pick(mode_i, line_nx, ph_use);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      ph_q   <= '0;
      idx_o  <= '0;
    end else if (stb_i) begin
      line_q <= line_nx;
      ph_q   <= ph_nx;
      idx_o  <= idx_nx;
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(idx_o));
  p_off_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && mode_i == MODE_OFF) |=> (idx_o == '0));
  p_user_direct_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && mode_i == MODE_USER) |=> (idx_o == $past({vd_i, hd_i})));
  p_tri_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && mode_i == MODE_TRI) |=> (idx_o != 2'd3));
  p_rep_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && mode_i == MODE_MOSAIC_REP) |=> (idx_o != 2'd3));
endmodule

// File: rtl/cfa_gain_mux.sv
module cfa_gain_mux
  import cfa_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic [NUM_GAINS*GAIN_W-1:0] gains_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic                        en_i,
  output logic [GAIN_W-1:0]           code_o
);
  localparam logic [GAIN_W-1:0] DEFAULT_CODE = '1;

  logic [GAIN_W-1:0] gain_arr [NUM_GAINS];

  for (genvar k = 0; k < NUM_GAINS; k++) begin : g_unpack
    assign gain_arr[k] = gains_i[k*GAIN_W +: GAIN_W];
  end

  assign code_o = en_i ? gain_arr[idx_i] : DEFAULT_CODE;
endmodule

// File: rtl/cfa_gain_steer.sv
module cfa_gain_steer
  import cfa_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pix_stb_i,
  input  logic                        vd_i,
  input  logic                        hd_i,
  input  logic [MODE_W-1:0]           mode_i,
  input  logic                        gain_en_i,
  input  logic [NUM_GAINS*GAIN_W-1:0] gains_i,
  output logic [IDX_W-1:0]            gain_idx_o,
  output logic [GAIN_W-1:0]           gain_code_o
);
  logic hd_rise, up_pend, dn_pend;

  cfa_edge_tracker u_edges (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (pix_stb_i),
    .vd_i        (vd_i),
    .hd_i        (hd_i),
    .hd_rise_o   (hd_rise),
    .vd_up_pend_o(up_pend),
    .vd_dn_pend_o(dn_pend)
  );

  cfa_pattern_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (pix_stb_i),
    .mode_i    (steer_mode_e'(mode_i)),
    .vd_i      (vd_i),
    .hd_i      (hd_i),
    .hd_rise_i (hd_rise),
    .up_pend_i (up_pend),
    .dn_pend_i (dn_pend),
    .idx_o     (gain_idx_o)
  );

  cfa_gain_mux #(.GAIN_W(GAIN_W)) u_mux (
    .gains_i(gains_i),
    .idx_i  (gain_idx_o),
    .en_i   (gain_en_i),
    .code_o (gain_code_o)
  );
endmodule

// File: tb/tb_cfa_gain_steer.sv
module tb_cfa_gain_steer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, stb, vd, hd, en;
  logic [2:0]  mode;
  logic [23:0] gains;
  logic [1:0]  idx;
  logic [5:0]  code;

  cfa_gain_steer dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_stb_i(stb), .vd_i(vd), .hd_i(hd),
    .mode_i(mode), .gain_en_i(en), .gains_i(gains),
    .gain_idx_o(idx), .gain_code_o(code)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int m_vd = 0, m_hd = 0, m_up = 0, m_dn = 0, m_line = 0, m_pos = 0, m_idx = 0;
  bit m_gap = 0, m_hr = 0;

  function automatic int pat_len(int md);
    return (md == 3) ? 3 : (md == 4) ? 4 : 2;
  endfunction

  function automatic int pat_at(int md, int ln, int p);
    if (md == 3 || md == 4) return p;
    if (md == 6) return ln + p;
    return 2 * ln + p;
  endfunction

  always @(posedge clk) begin
    int up, dn, hr;
    bit two;
    if (!rst_n) begin
      m_vd = 0; m_hd = 0; m_up = 0; m_dn = 0; m_line = 0; m_pos = 0; m_idx = 0;
      m_gap = 0; m_hr = 0;
    end else if (!stb) begin
      m_gap = 1;
    end else begin
      m_gap = 0;
      up = (m_up != 0 || (vd && m_vd == 0)) ? 1 : 0;
      dn = (m_dn != 0 || (!vd && m_vd == 1)) ? 1 : 0;
      hr = (hd && m_hd == 0) ? 1 : 0;
      m_hr = (hr != 0);
      two = (mode == 1 || mode == 2 || mode == 5 || mode == 6);
      if (mode == 0) begin
        m_idx = 0; m_pos = 0;
      end else if (mode == 7) begin
        m_idx = (vd ? 2 : 0) + (hd ? 1 : 0); m_pos = 0;
      end else begin
        if (hr != 0 && two) begin
          if (mode == 1 || mode == 6) m_line = (up != 0) ? 0 : 1 - m_line;
          else if (mode == 2) m_line = (up != 0 || dn != 0) ? 0 : 1 - m_line;
          else m_line = (dn != 0) ? 0 : ((up != 0) ? 1 : m_line);
        end
        if (hr != 0 && (two || up != 0)) m_pos = 0;
        if (m_pos >= pat_len(mode)) m_pos = 0;
        m_idx = pat_at(mode, m_line, m_pos);
        m_pos = (m_pos + 1) % pat_len(mode);
      end
      if (hr != 0) begin m_up = 0; m_dn = 0; end
      else begin m_up = up; m_dn = dn; end
      m_vd = vd ? 1 : 0;
      m_hd = hd ? 1 : 0;
    end
  end

  function automatic string tag();
    if (m_gap) return "R2";
    if (!en) return "R3";
    if (m_hr && mode != 0 && mode != 7) return "R12";
    case (mode)
      3'd0: return "R11";
      3'd1: return "R4";
      3'd2: return "R7";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare away from both clock edges
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(tag(), int'(idx), m_idx);
      check(en ? tag() : "R3", int'(code), en ? int'(gains[m_idx*6 +: 6]) : 63);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic cyc(input bit v, input bit h, input bit s = 1'b1);
    @(negedge clk);
    vd = v; hd = h; stb = s;
  endtask

  task automatic line(input int n, input bit v);
    cyc(v, 1); cyc(v, 1);
    for (int i = 0; i < n; i++) cyc(v, 0, (i == 3) ? 1'b0 : 1'b1);
  endtask

  task automatic frame();
    cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0);
    for (int i = 0; i < 3; i++) line(7, 0);
    cyc(1, 0); cyc(1, 0);
    for (int i = 0; i < 2; i++) line(7, 1);
    cyc(0, 0);
    for (int i = 0; i < 2; i++) line(7, 0);
  endtask

  initial begin
    rst_n = 0; stb = 0; vd = 0; hd = 0; en = 1; mode = 3'd1;
    gains = {6'd40, 6'd30, 6'd20, 6'd10};
    repeat (3) @(negedge clk);
    #5;
    check("R1", int'(idx), 0);
    check("R1", int'(code), 10);
    en = 0; #1;
    check("R1", int'(code), 63);
    en = 1;
    @(negedge clk); rst_n = 1;

    for (int m = 1; m <= 6; m++) begin
      mode = 3'(m);
      frame();
    end

    // mid-line switch from four-color to three-color
    mode = 3'd4;
    frame();
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    mode = 3'd3;
    for (int i = 0; i < 6; i++) cyc(0, 0);
    line(6, 0);

    mode = 3'd7;
    for (int i = 0; i < 16; i++) cyc(i[1], i[0], i != 9);

    mode = 3'd0;
    frame();

    mode = 3'd4; en = 0;
    frame();
    en = 1;
    gains = {6'd5, 6'd17, 6'd33, 6'd62};
    mode = 3'd5;
    frame();

    cyc(0, 0); cyc(0, 0);
    @(negedge clk); #7;
    finish_run();
  end
endmodule